// File: doc/BRIEF.md
# GPIO Input Change Interrupt Unit

This block watches a set of already-synchronized pin levels, grouped into byte-wide ports, and tells a host when any of them has moved away from the value the host last captured. Each pin has a direction bit, a polarity-invert bit, an interrupt mask bit and a latch-enable bit. The unit presents an Input register value per pin, a per-pin interrupt source (status) vector, and one active-low interrupt line. The line is meant to drive an open-drain style pad elsewhere.

Software reads a port by pulsing that port's read strobe for one cycle while it samples the Input register value. That read recaptures the reference levels of the port and clears its pending sources. A non-latched pin clears its own source when it returns to the captured level. A latched pin keeps its changed value and its source until the port is read, even if it has already returned.

Top module: `gpio_chg_irq`

## Requirements
- R1: A level change on an unmasked pin configured as input (`dir_in_i` bit = 1) sets that pin's `status_o` bit and drives `irq_n_o` low at the first rising clock edge that samples the change.
- R2: The internal mask register resets to all ones (1 = masked). While `rst` is high and in the first cycle after it, `irq_n_o` is 1 and `status_o` is 0. The reference levels are captured from the pins at reset.
- R3: A non-latched pin whose level returns to its captured reference clears its `status_o` bit, and `irq_n_o` rises when no other source remains.
- R4: `status_o` bit p*8+k marks pin k of port p as a source, and several bits may be set at once. `irq_n_o` is 0 exactly when any `status_o` bit is 1.
- R5: A pin whose `mask_i` bit is 1 never sets its status bit. `mask_i` acts through one register stage. A difference that is still present when the pin is unmasked then raises the interrupt.
- R6: A one-cycle pulse on `rd_stb_i` bit p recaptures the shown levels of port p only and clears that port's sources. The other port's status is unchanged.
- R7: With its `latch_en_i` bit set, an input pin holds its changed value in `in_reg_o` and keeps its status bit until its port is read, even after the pin returns. After the read, `in_reg_o` shows the current level.
- R8: When a latched and a non-latched pin change together and the non-latched one returns, `irq_n_o` stays low.
- R9: `in_reg_o` shows every pin's level one cycle later, whatever its direction. The level is inverted only when `pol_inv_i` and `dir_in_i` are both 1 for that pin.
- R10: A pin configured as output (`dir_in_i` bit = 0) never sets a status bit.
- R11: A change that arrives in the same cycle as a read strobe of its port is not lost. The status bit stays set and `irq_n_o` stays low, for latched and non-latched pins alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | PORTS*PORT_W | Synchronized pin levels, bit p*PORT_W+k = port p pin k |
| rd_stb_i | input | PORTS | One-cycle port read strobe, bit p = port p |
| dir_in_i | input | PORTS*PORT_W | 1 = pin is an input |
| mask_i | input | PORTS*PORT_W | 1 = interrupt masked |
| latch_en_i | input | PORTS*PORT_W | 1 = input latch mode |
| pol_inv_i | input | PORTS*PORT_W | 1 = invert level of an input pin |
| irq_n_o | output | 1 | Active-low interrupt |
| in_reg_o | output | PORTS*PORT_W | Input register values |
| status_o | output | PORTS*PORT_W | Interrupt source per pin |

## Verification
The bench builds the block with its defaults: two ports of eight pins, 16 bits in all. With two ports, a strobe that clears one port's sources can be shown to leave the other port's pending source in place. A latched pin and a non-latched pin can be placed in the same port and in different ports. Because the port width is eight, a wrong slice offset in the port generate loop moves a status bit by a whole byte, and the bench notices that.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;

  parameter int unsigned PORT_W_DEF = 8;
  parameter int unsigned PORTS_DEF  = 2;

  // level seen by the Input register: inversion only on input pins
  function automatic logic shown_level(input logic raw, input logic is_in,
                                       input logic inv);
    return raw ^ (is_in & inv);
  endfunction

endpackage

// File: rtl/chg_polarity.sv
module chg_polarity
  import gpio_chg_pkg::*;
#(
  parameter int unsigned W = PORT_W_DEF
) (
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] dir_in_i,
  input  logic [W-1:0] inv_i,
  output logic [W-1:0] lvl_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign lvl_o[b] = shown_level(raw_i[b], dir_in_i[b], inv_i[b]);
  end

endmodule

// File: rtl/chg_port_track.sv
module chg_port_track #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  input  logic         rd_i,
  input  logic [W-1:0] dir_in_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] latch_en_i,
  output logic [W-1:0] in_o,
  output logic [W-1:0] status_o,
  output logic [W-1:0] status_nxt_o
);

  logic [W-1:0] lvl_q, ref_q, lat_q, latv_q, mask_q;
  logic [W-1:0] ref_d, lat_d, latv_d, stat_d;

  always_comb begin
    for (int b = 0; b < W; b++) begin
      ref_d[b]  = ref_q[b];
      lat_d[b]  = lat_q[b];
      latv_d[b] = latv_q[b];
      if (!dir_in_i[b]) begin
        // outputs follow the pin so a later turn to input starts quiet
        ref_d[b] = lvl_i[b];
        lat_d[b] = 1'b0;
      end else if (rd_i) begin
        // recapture the level that was on show; an edge in this cycle survives
        ref_d[b]  = lvl_q[b];
        lat_d[b]  = latch_en_i[b] & (lvl_i[b] ^ lvl_q[b]);
        latv_d[b] = lvl_i[b];
      end else if (!latch_en_i[b]) begin
        lat_d[b] = 1'b0;
      end else if (!lat_q[b] && (lvl_i[b] ^ ref_q[b])) begin
        lat_d[b]  = 1'b1;
        latv_d[b] = lvl_i[b];
      end
      stat_d[b] = dir_in_i[b] & ~mask_q[b] & (lat_d[b] | (lvl_i[b] ^ ref_d[b]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q    <= lvl_i;
      ref_q    <= lvl_i;
      lat_q    <= '0;
      latv_q   <= '0;
      mask_q   <= '1;
      status_o <= '0;
    end else begin
      lvl_q    <= lvl_i;
      ref_q    <= ref_d;
      lat_q    <= lat_d;
      latv_q   <= latv_d;
      mask_q   <= mask_i;
      status_o <= stat_d;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_show
    assign in_o[b] = lat_q[b] ? latv_q[b] : lvl_q[b];
  end

  assign status_nxt_o = rst ? '0 : stat_d;

endmodule

// File: rtl/chg_irq_merge.sv
module chg_irq_merge #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_nxt_i,
  output logic         irq_n_o
);

  always_ff @(posedge clk) begin
    if (rst) irq_n_o <= 1'b1;
    else     irq_n_o <= ~(|src_nxt_i);
  end

endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
  import gpio_chg_pkg::*;
#(
  parameter int unsigned PORT_W = PORT_W_DEF,
  parameter int unsigned PORTS  = PORTS_DEF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [PORTS*PORT_W-1:0]  pin_i,
  input  logic [PORTS-1:0]         rd_stb_i,
  input  logic [PORTS*PORT_W-1:0]  dir_in_i,
  input  logic [PORTS*PORT_W-1:0]  mask_i,
  input  logic [PORTS*PORT_W-1:0]  latch_en_i,
  input  logic [PORTS*PORT_W-1:0]  pol_inv_i,
  output logic                     irq_n_o,
  output logic [PORTS*PORT_W-1:0]  in_reg_o,
  output logic [PORTS*PORT_W-1:0]  status_o
);

  localparam int unsigned N = PORTS * PORT_W;

  logic [N-1:0] lvl;
  logic [N-1:0] stat_nxt;

  chg_polarity #(.W(N)) u_pol (
    .raw_i    (pin_i),
    .dir_in_i (dir_in_i),
    .inv_i    (pol_inv_i),
    .lvl_o    (lvl)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    chg_port_track #(.W(PORT_W)) u_trk (
      .clk          (clk),
      .rst          (rst),
      .lvl_i        (lvl[p*PORT_W +: PORT_W]),
      .rd_i         (rd_stb_i[p]),
      .dir_in_i     (dir_in_i[p*PORT_W +: PORT_W]),
      .mask_i       (mask_i[p*PORT_W +: PORT_W]),
      .latch_en_i   (latch_en_i[p*PORT_W +: PORT_W]),
      .in_o         (in_reg_o[p*PORT_W +: PORT_W]),
      .status_o     (status_o[p*PORT_W +: PORT_W]),
      .status_nxt_o (stat_nxt[p*PORT_W +: PORT_W])
    );
  end

  chg_irq_merge #(.N(N)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .src_nxt_i (stat_nxt),
    .irq_n_o   (irq_n_o)
  );

endmodule

// File: rtl/gpio_chg_irq_chk.sv
module gpio_chg_irq_chk #(
  parameter int unsigned N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] dir_in_i,
  input logic [N-1:0] mask_i,
  input logic         irq_n_o,
  input logic [N-1:0] status_o
);

  // R2: first cycle after reset is quiet
  a_r2_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_n_o && status_o == '0));

  // R4: line low exactly when a source is flagged
  a_r4_line_tracks_status: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == ~(|status_o));

  // R5: masked pins never flagged
  a_r5_masked_silent: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> ((status_o & $past(mask_i, 2)) == '0));

  // R10: output pins never flagged
  a_r10_outputs_silent: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status_o & ~$past(dir_in_i)) == '0));

endmodule

bind gpio_chg_irq gpio_chg_irq_chk #(.N(PORTS*PORT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dir_in_i (dir_in_i),
  .mask_i   (mask_i),
  .irq_n_o  (irq_n_o),
  .status_o (status_o)
);

// File: tb/test_gpio_chg_irq.sv
`timescale 1ns/1ps
module test_gpio_chg_irq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] pin = '0, dir = '1, mask = '1, latch = '0, pol = '0;
  logic [1:0]  rd = '0;
  logic        irq_n;
  logic [15:0] in_reg, status;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  gpio_chg_irq i_gpio_chg_irq (
    .clk(clk), .rst(rst), .pin_i(pin), .rd_stb_i(rd), .dir_in_i(dir),
    .mask_i(mask), .latch_en_i(latch), .pol_inv_i(pol),
    .irq_n_o(irq_n), .in_reg_o(in_reg), .status_o(status)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_ports();
    rd = 2'b11; step(); rd = 2'b00; step();
  endtask

  task automatic t_reset();
    mask = '0; pin = 16'h0008;
    repeat (3) step();
    chk("R2 irq in reset", {15'd0, irq_n}, 16'h0001);
    chk("R2 status in reset", status, 16'h0000);
    rst = 1'b0; step();
    chk("R2 irq after reset", {15'd0, irq_n}, 16'h0001);
    chk("R2 status after reset", status, 16'h0000);
    chk("R9 in_reg captured", in_reg, 16'h0008);
  endtask

  task automatic t_change_return();
    pin = 16'h0000; step();
    chk("R1 status on fall", status, 16'h0008);
    chk("R1 irq on fall", {15'd0, irq_n}, 16'h0000);
    pin = 16'h0008; step();
    chk("R3 return clears status", status, 16'h0000);
    chk("R3 return clears irq", {15'd0, irq_n}, 16'h0001);
    pin = 16'h0000; step(); clear_ports();
    pin = 16'h0004; step();
    chk("R1 status on rise", status, 16'h0004);
    chk("R9 in_reg follows", in_reg, 16'h0004);
    pin = 16'h0000; step();
    chk("R3 irq after return", {15'd0, irq_n}, 16'h0001);
  endtask

  task automatic t_port_read();
    pin = 16'h0202; step();
    chk("R4 two sources", status, 16'h0202);
    rd = 2'b01; step(); rd = 2'b00;
    chk("R6 port0 read clears own", status, 16'h0200);
    chk("R6 irq kept by port1", {15'd0, irq_n}, 16'h0000);
    rd = 2'b10; step(); rd = 2'b00;
    chk("R6 port1 read clears", status, 16'h0000);
    chk("R6 irq released", {15'd0, irq_n}, 16'h0001);
    pin = 16'h0000; step(); clear_ports();
    chk("R6 clean after restore", status, 16'h0000);
  endtask

  task automatic t_outputs();
    dir = ~16'h0010; pol = 16'h0010; pin = 16'h0010; step();
    chk("R10 output pin no status", status, 16'h0000);
    chk("R10 output pin no irq", {15'd0, irq_n}, 16'h0001);
    chk("R9 output pin not inverted", in_reg, 16'h0010);
    pin = 16'h0000; pol = '0; step();
    dir = '1; step();
    chk("R10 quiet after turn to input", {15'd0, irq_n}, 16'h0001);
  endtask

  task automatic t_polarity();
    pol = 16'h0040; step();
    chk("R9 inverted input shown", in_reg, 16'h0040);
    chk("R1 inversion is a change", status, 16'h0040);
    clear_ports();
    chk("R3 read clears inverted", {15'd0, irq_n}, 16'h0001);
    pol = '0; step(); clear_ports();
    chk("R9 back to plain level", in_reg, 16'h0000);
  endtask

  task automatic t_mask();
    mask = 16'h0400; step();
    pin = 16'h0400; step();
    chk("R5 masked no status", status, 16'h0000);
    chk("R5 masked no irq", {15'd0, irq_n}, 16'h0001);
    chk("R9 masked pin still shown", in_reg, 16'h0400);
    mask = '0; step(); step();
    chk("R5 pending surfaces on unmask", status, 16'h0400);
    pin = 16'h0000; step();
    chk("R3 clears after unmask", {15'd0, irq_n}, 16'h0001);
  endtask

  task automatic t_latch();
    latch = 16'h1000; pin = 16'h1000; step();
    chk("R7 latched source", status, 16'h1000);
    pin = 16'h0000; step();
    chk("R7 source held after return", status, 16'h1000);
    chk("R7 value held", in_reg, 16'h1000);
    rd = 2'b10;
    chk("R7 read sees held value", in_reg, 16'h1000);
    step(); rd = 2'b00;
    chk("R7 read clears", {15'd0, irq_n}, 16'h0001);
    chk("R7 current level after read", in_reg, 16'h0000);
    pin = 16'h3000; step();
    chk("R8 both flagged", status, 16'h3000);
    pin = 16'h1000; step();
    chk("R8 irq stays low", {15'd0, irq_n}, 16'h0000);
    chk("R8 latched source remains", status, 16'h1000);
    pin = 16'h0000; step(); clear_ports();
    chk("R8 cleared", {15'd0, irq_n}, 16'h0001);
    latch = '0; step();
  endtask

  task automatic t_priority();
    pin = 16'h0001; rd = 2'b01; step(); rd = 2'b00;
    chk("R11 change during read kept", status, 16'h0001);
    chk("R11 irq kept", {15'd0, irq_n}, 16'h0000);
    clear_ports();
    chk("R11 later read clears", {15'd0, irq_n}, 16'h0001);
    latch = 16'h0008; pin = 16'h0009; rd = 2'b01; step(); rd = 2'b00;
    chk("R11 latched change during read", status, 16'h0008);
    pin = 16'h0001; step();
    chk("R11 latched value held", in_reg, 16'h0009);
    clear_ports();
    chk("R11 latched cleared", status, 16'h0000);
    latch = '0; pin = 16'h0000; step(); clear_ports();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_change_return();
    t_port_read();
    t_outputs();
    t_polarity();
    t_mask();
    t_latch();
    t_priority();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule